// File: doc/BRIEF.md
# DRAM Low-Power State Sequencer

This block sits beside a DRAM controller and decides when the attached memory may leave normal operation for one of two low-power states: self-refresh, which keeps the memory contents, and deep power-down, which drops them. It decodes the configured memory family from three configuration inputs. It stops new accesses while it waits for traffic to drain. It then issues abstract enter and exit commands on a small command port and waits for a completion pulse on each one.

Any access presented while the memory is in a low-power state is answered at once with an error response. The access is never stalled there. Deep power-down is honoured only when the configuration selects low-power DDR. On exit from deep power-down the block holds a re-initialization flag and keeps rejecting accesses until the initialization-done input arrives. Exit from self-refresh returns straight to normal service.

Top module: `lpm_seq`

## Requirements
- R1: `memKind` decodes the configuration as follows. It is 2'b00 (DDR2) when `cfgPhyMode`=2'b01 with `cfgDdr3En`=0 and `cfgLpEn`=0. It is 2'b01 (DDR3) when `cfgPhyMode`=2'b00 with `cfgDdr3En`=1 and `cfgLpEn`=0. It is 2'b10 (LPDDR) when `cfgPhyMode`=2'b11 with `cfgLpEn`=1 and `cfgDdr3En`=0. Every other combination gives 2'b11 (invalid).
- R2: `idle` is high only when three conditions hold together: no accepted access is still waiting for `memRspDone`, `accReq` is low, and `cmdValid` is low. After reset it is high.
- R3: After a low-power request is taken, `accRdy` is low and no enter command is issued while any accepted access is outstanding. The enter command starts only once the outstanding count is zero.
- R4: `cmdOp` is encoded as 0 = enter self-refresh, 1 = exit self-refresh, 2 = enter deep power-down, 3 = exit deep power-down. `cmdValid` and `cmdOp` stay constant until the cycle in which `cmdDone` is sampled high.
- R5: On `srReq`, the block issues op 0. `srAck` rises the cycle after that command completes and stays high while `srReq` is held. When `srReq` drops, the block issues op 1, and `srAck` falls the cycle after it completes. `needInit` stays low throughout.
- R6: `dpdReq` has no effect unless `memKind` is 2'b10. In that case no command is issued, `dpdAck` stays low and accesses are still served.
- R7: With `memKind`=2'b10, `dpdReq` leads to op 2. `dpdAck` rises after completion and holds while `dpdReq` is high. Dropping `dpdReq` leads to op 3. On that completion `dpdAck` clears and `needInit` sets in the same cycle.
- R8: `needInit` clears the cycle after `initDone` is seen. Until then, accesses receive error responses.
- R9: Each accepted `accReq` gets a one-cycle `accRsp` on the next cycle. `accErr` is 0 in normal service and 1 from the enter command up to re-entry to normal service.
- R10: When both requests are high in normal service, deep power-down (op 2) is chosen if `memKind` is 2'b10. Otherwise self-refresh (op 0) is chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgDdr3En | input | 1 | DDR3 enable configuration bit |
| cfgLpEn | input | 1 | Low-power DDR enable configuration bit |
| cfgPhyMode | input | 2 | PHY memory-family field |
| srReq | input | 1 | Self-refresh request level |
| dpdReq | input | 1 | Deep power-down request level |
| initDone | input | 1 | Re-initialization finished pulse |
| accReq | input | 1 | Read or write access request |
| accRdy | output | 1 | Access may be presented this cycle |
| accRsp | output | 1 | Response strobe for a taken access |
| accErr | output | 1 | Response carries a bus error |
| memRspDone | input | 1 | One accepted access has finished in memory |
| cmdValid | output | 1 | Enter/exit command pending |
| cmdOp | output | 2 | Command code (see R4) |
| cmdDone | input | 1 | Command completion pulse |
| memKind | output | 2 | Decoded memory family (see R1) |
| idle | output | 1 | No activity in the controller |
| srAck | output | 1 | Memory is in self-refresh |
| dpdAck | output | 1 | Memory is in deep power-down |
| needInit | output | 1 | Re-initialization required |

## Verification
A sequencer stuck in the wrong state shows at the ports on the very next access. That access comes back with the wrong `accErr`, or it sees `accRdy` low when it should be high. The bench therefore probes with one access after each transition. A wrong acknowledge flag shows within one cycle of the command's completion, because the flags follow `cmdDone` directly. A wrong drain decision shows as `cmdValid` rising while an access is still open. The bench looks for that in the cycles right after the request.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [3:0] {
    ST_RUN,
    ST_SR_WAIT,
    ST_SR_ENTER,
    ST_SR_HOLD,
    ST_SR_EXIT,
    ST_DPD_WAIT,
    ST_DPD_ENTER,
    ST_DPD_HOLD,
    ST_DPD_EXIT,
    ST_UNINIT
  } lpmState_e;

  typedef enum logic [1:0] {
    OP_SR_IN   = 2'd0,
    OP_SR_OUT  = 2'd1,
    OP_DPD_IN  = 2'd2,
    OP_DPD_OUT = 2'd3
  } lpmOp_e;

  localparam logic [1:0] KIND_DDR2  = 2'b00;
  localparam logic [1:0] KIND_DDR3  = 2'b01;
  localparam logic [1:0] KIND_LPDDR = 2'b10;
  localparam logic [1:0] KIND_BAD   = 2'b11;

  // strobes from control to datapath
  typedef struct packed {
    logic accOpen;
    logic accReject;
    logic cmdBusy;
    logic setSr;
    logic clrSr;
    logic setDpd;
    logic clrDpd;
    logic setInit;
    logic clrInit;
  } lpmStrb_t;

  // status from datapath to control
  typedef struct packed {
    logic cntZero;
    logic cntFull;
    logic lpOk;
  } lpmStat_t;

endpackage

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       srReq,
  input  logic       dpdReq,
  input  logic       initDone,
  input  logic       cmdDone,
  input  lpmStat_t   stat,
  output lpmStrb_t   strb,
  output logic       cmdValid,
  output logic [1:0] cmdOp
);

  lpmState_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_RUN: begin
        if (dpdReq && stat.lpOk) stateNext = ST_DPD_WAIT;
        else if (srReq)          stateNext = ST_SR_WAIT;
      end
      ST_SR_WAIT: begin
        if (!srReq)             stateNext = ST_RUN;
        else if (stat.cntZero)  stateNext = ST_SR_ENTER;
      end
      ST_SR_ENTER: if (cmdDone) stateNext = ST_SR_HOLD;
      ST_SR_HOLD:  if (!srReq)  stateNext = ST_SR_EXIT;
      ST_SR_EXIT:  if (cmdDone) stateNext = ST_RUN;
      ST_DPD_WAIT: begin
        if (!dpdReq)            stateNext = ST_RUN;
        else if (stat.cntZero)  stateNext = ST_DPD_ENTER;
      end
      ST_DPD_ENTER: if (cmdDone) stateNext = ST_DPD_HOLD;
      ST_DPD_HOLD:  if (!dpdReq) stateNext = ST_DPD_EXIT;
      ST_DPD_EXIT:  if (cmdDone) stateNext = ST_UNINIT;
      ST_UNINIT:    if (initDone) stateNext = ST_RUN;
      default:      stateNext = ST_RUN;
    endcase
  end

  always_comb begin
    cmdValid = 1'b0;
    cmdOp    = OP_SR_IN;
    unique case (state)
      ST_SR_ENTER:  begin cmdValid = 1'b1; cmdOp = OP_SR_IN;   end
      ST_SR_EXIT:   begin cmdValid = 1'b1; cmdOp = OP_SR_OUT;  end
      ST_DPD_ENTER: begin cmdValid = 1'b1; cmdOp = OP_DPD_IN;  end
      ST_DPD_EXIT:  begin cmdValid = 1'b1; cmdOp = OP_DPD_OUT; end
      default:      begin cmdValid = 1'b0; cmdOp = OP_SR_IN;   end
    endcase
  end

  always_comb begin
    strb           = '0;
    strb.cmdBusy   = cmdValid;
    strb.accOpen   = (state == ST_RUN) && !stat.cntFull;
    strb.accReject = (state != ST_RUN) && (state != ST_SR_WAIT) &&
                     (state != ST_DPD_WAIT);
    strb.setSr     = (state == ST_SR_ENTER)  && cmdDone;
    strb.clrSr     = (state == ST_SR_EXIT)   && cmdDone;
    strb.setDpd    = (state == ST_DPD_ENTER) && cmdDone;
    strb.clrDpd    = (state == ST_DPD_EXIT)  && cmdDone;
    strb.setInit   = (state == ST_DPD_EXIT)  && cmdDone;
    strb.clrInit   = (state == ST_UNINIT)    && initDone;
  end

endmodule

// File: rtl/lpm_dp.sv
module lpm_dp
  import lpm_pkg::*;
#(
  parameter int OUT_W = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgDdr3En,
  input  logic       cfgLpEn,
  input  logic [1:0] cfgPhyMode,
  input  logic       accReq,
  input  logic       memRspDone,
  input  lpmStrb_t   strb,
  output lpmStat_t   stat,
  output logic       accRdy,
  output logic       accRsp,
  output logic       accErr,
  output logic [1:0] memKind,
  output logic       idle,
  output logic       srAck,
  output logic       dpdAck,
  output logic       needInit
);

  localparam logic [OUT_W-1:0] CNT_MAX = {OUT_W{1'b1}};

  logic [OUT_W-1:0] outCnt;
  logic             takeOk;
  logic             takeErr;

  // memory family decode
  always_comb begin
    if (cfgPhyMode == 2'b01 && !cfgDdr3En && !cfgLpEn)      memKind = KIND_DDR2;
    else if (cfgPhyMode == 2'b00 && cfgDdr3En && !cfgLpEn)  memKind = KIND_DDR3;
    else if (cfgPhyMode == 2'b11 && cfgLpEn && !cfgDdr3En)  memKind = KIND_LPDDR;
    else                                                   memKind = KIND_BAD;
  end

  assign takeOk  = accReq && strb.accOpen;
  assign takeErr = accReq && strb.accReject;
  assign accRdy  = strb.accOpen || strb.accReject;

  // outstanding access counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outCnt <= '0;
    end else begin
      case ({takeOk, memRspDone && (outCnt != '0)})
        2'b10:   outCnt <= outCnt + 1'b1;
        2'b01:   outCnt <= outCnt - 1'b1;
        default: outCnt <= outCnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accRsp <= 1'b0;
      accErr <= 1'b0;
    end else begin
      accRsp <= takeOk || takeErr;
      accErr <= takeErr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srAck    <= 1'b0;
      dpdAck   <= 1'b0;
      needInit <= 1'b0;
    end else begin
      if (strb.setSr)        srAck <= 1'b1;
      else if (strb.clrSr)   srAck <= 1'b0;
      if (strb.setDpd)       dpdAck <= 1'b1;
      else if (strb.clrDpd)  dpdAck <= 1'b0;
      if (strb.setInit)      needInit <= 1'b1;
      else if (strb.clrInit) needInit <= 1'b0;
    end
  end

  assign stat.cntZero = (outCnt == '0);
  assign stat.cntFull = (outCnt == CNT_MAX);
  assign stat.lpOk    = (memKind == KIND_LPDDR);

  assign idle = stat.cntZero && !accReq && !strb.cmdBusy;

endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
  import lpm_pkg::*;
#(
  parameter int OUT_W = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgDdr3En,
  input  logic       cfgLpEn,
  input  logic [1:0] cfgPhyMode,
  input  logic       srReq,
  input  logic       dpdReq,
  input  logic       initDone,
  input  logic       accReq,
  output logic       accRdy,
  output logic       accRsp,
  output logic       accErr,
  input  logic       memRspDone,
  output logic       cmdValid,
  output logic [1:0] cmdOp,
  input  logic       cmdDone,
  output logic [1:0] memKind,
  output logic       idle,
  output logic       srAck,
  output logic       dpdAck,
  output logic       needInit
);

  lpmStrb_t strb;
  lpmStat_t stat;
  logic     outZero;

  assign outZero = stat.cntZero;

  lpm_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .srReq    (srReq),
    .dpdReq   (dpdReq),
    .initDone (initDone),
    .cmdDone  (cmdDone),
    .stat     (stat),
    .strb     (strb),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp)
  );

  lpm_dp #(.OUT_W(OUT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cfgDdr3En  (cfgDdr3En),
    .cfgLpEn    (cfgLpEn),
    .cfgPhyMode (cfgPhyMode),
    .accReq     (accReq),
    .memRspDone (memRspDone),
    .strb       (strb),
    .stat       (stat),
    .accRdy     (accRdy),
    .accRsp     (accRsp),
    .accErr     (accErr),
    .memKind    (memKind),
    .idle       (idle),
    .srAck      (srAck),
    .dpdAck     (dpdAck),
    .needInit   (needInit)
  );

endmodule

// File: rtl/lpm_seq_chk.sv
module lpm_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       accReq,
  input logic       accRsp,
  input logic       accErr,
  input logic       cmdValid,
  input logic [1:0] cmdOp,
  input logic       cmdDone,
  input logic       srAck,
  input logic       dpdAck,
  input logic       needInit,
  input logic       outZero,
  input logic       idle
);

  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdDone |=> cmdValid && $stable(cmdOp)) else $error("cmd dropped"); // R4

  AST_ENTER_DRAINED: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && (cmdOp == 2'd0 || cmdOp == 2'd2) |-> outZero) else $error("enter not drained"); // R3

  AST_ERR_IN_RSP: assert property (@(posedge clk) disable iff (!rstN)
    accErr |-> accRsp) else $error("error without response"); // R9

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    accRsp |-> $past(accReq)) else $error("response without request"); // R9

  AST_ACKS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(srAck && dpdAck)) else $error("both acks"); // R5

  AST_INIT_ON_DPD_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(needInit) |-> $fell(dpdAck)) else $error("needInit without dpd exit"); // R7

  AST_IDLE_NO_CMD: assert property (@(posedge clk) disable iff (!rstN)
    idle |-> !cmdValid && !accReq) else $error("idle while busy"); // R2

endmodule

bind lpm_seq lpm_seq_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .accReq   (accReq),
  .accRsp   (accRsp),
  .accErr   (accErr),
  .cmdValid (cmdValid),
  .cmdOp    (cmdOp),
  .cmdDone  (cmdDone),
  .srAck    (srAck),
  .dpdAck   (dpdAck),
  .needInit (needInit),
  .outZero  (outZero),
  .idle     (idle)
);

// File: tb/lpm_seq_test.sv
`timescale 1ns/1ps
module lpm_seq_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgDdr3En = 1'b0, cfgLpEn = 1'b0;
  logic [1:0] cfgPhyMode = 2'b01;
  logic       srReq = 1'b0, dpdReq = 1'b0, initDone = 1'b0, accReq = 1'b0;
  logic       accRdy, accRsp, accErr, cmdValid, idle, srAck, dpdAck, needInit;
  logic       memRspDone;
  logic       cmdDone = 1'b0;
  logic [1:0] cmdOp, memKind;
  logic [3:0] pend = '0;
  int         cmdCnt = 0;
  int         nRun = 0, nFail = 0;
  logic       expQ[$];
  logic       done = 1'b0;

  always #10 clk = ~clk;

  lpm_seq uut (
    .clk(clk), .rstN(rstN), .cfgDdr3En(cfgDdr3En), .cfgLpEn(cfgLpEn),
    .cfgPhyMode(cfgPhyMode), .srReq(srReq), .dpdReq(dpdReq),
    .initDone(initDone), .accReq(accReq), .accRdy(accRdy), .accRsp(accRsp),
    .accErr(accErr), .memRspDone(memRspDone), .cmdValid(cmdValid),
    .cmdOp(cmdOp), .cmdDone(cmdDone), .memKind(memKind), .idle(idle),
    .srAck(srAck), .dpdAck(dpdAck), .needInit(needInit)
  );

  // memory stubs: access finishes 4 cycles after response; command after 3
  assign memRspDone = pend[3];
  always @(posedge clk) begin
    pend <= {pend[2:0], accRsp && !accErr};
    if (cmdValid && !cmdDone) begin
      if (cmdCnt == 2) begin cmdDone <= 1'b1; cmdCnt <= 0; end
      else cmdCnt <= cmdCnt + 1;
    end else cmdDone <= 1'b0;
  end

  task automatic check(input string req, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: one access, expected error flag pushed to scoreboard
  task automatic doAccess(input logic expErr);
    @(negedge clk);
    accReq = 1'b1;
    expQ.push_back(expErr);
    @(negedge clk);
    accReq = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rstN && accRsp) begin
      if (expQ.size() == 0) check("R9 unexpected rsp", 1, 0);
      else check("R9 accErr", accErr, expQ.pop_front());
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFail++; nRun++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    // reset state
    check("R2 idle after reset", idle, 1);
    check("R5 srAck reset", srAck, 0);
    check("R7 dpdAck reset", dpdAck, 0);
    check("R8 needInit reset", needInit, 0);
    check("R4 cmdValid reset", cmdValid, 0);

    // R1 decode
    check("R1 ddr2", memKind, 0);
    cfgDdr3En = 1; cfgPhyMode = 2'b00; cyc(1);
    check("R1 ddr3", memKind, 1);
    cfgDdr3En = 0; cfgLpEn = 1; cfgPhyMode = 2'b11; cyc(1);
    check("R1 lpddr", memKind, 2);
    cfgDdr3En = 1; cyc(1);
    check("R1 invalid", memKind, 3);
    cfgDdr3En = 0; cfgLpEn = 0; cfgPhyMode = 2'b01; cyc(1);

    // R9 normal access, R2 idle drops while outstanding
    doAccess(0);
    check("R2 idle low outstanding", idle, 0);
    cyc(8);
    check("R2 idle after drain", idle, 1);

    // R3 drain before self-refresh entry
    doAccess(0);
    srReq = 1;
    cyc(1);
    check("R3 accRdy low in wait", accRdy, 0);
    check("R3 no enter while busy", cmdValid, 0);
    cyc(12);
    check("R5 srAck set", srAck, 1);
    check("R5 no cmd in hold", cmdValid, 0);
    doAccess(1);
    doAccess(1);
    srReq = 0;
    cyc(1);
    check("R4 exit op", cmdOp, 1);
    check("R4 exit valid", cmdValid, 1);
    check("R9 err during exit cmd", accRdy, 1);
    cyc(8);
    check("R5 srAck cleared", srAck, 0);
    check("R5 no needInit", needInit, 0);
    doAccess(0);
    cyc(6);

    // R6 dpd ignored without LPDDR
    dpdReq = 1;
    cyc(8);
    check("R6 no cmd", cmdValid, 0);
    check("R6 no dpdAck", dpdAck, 0);
    doAccess(0);
    dpdReq = 0;
    cyc(6);

    // R7 deep power-down in LPDDR
    cfgLpEn = 1; cfgPhyMode = 2'b11; cyc(1);
    dpdReq = 1;
    cyc(2);
    check("R4 enter dpd op", cmdOp, 2);
    cyc(8);
    check("R7 dpdAck set", dpdAck, 1);
    doAccess(1);
    dpdReq = 0;
    cyc(8);
    check("R7 dpdAck cleared", dpdAck, 0);
    check("R7 needInit set", needInit, 1);
    doAccess(1);
    cyc(2);
    initDone = 1; cyc(1); initDone = 0;
    check("R8 needInit cleared", needInit, 0);
    doAccess(0);
    cyc(6);

    // R10 priority
    srReq = 1; dpdReq = 1;
    cyc(2);
    check("R10 dpd chosen", cmdOp, 2);
    check("R10 dpd cmd", cmdValid, 1);
    cyc(8);
    check("R10 srAck low", srAck, 0);
    srReq = 0; dpdReq = 0;
    cyc(8);
    initDone = 1; cyc(1); initDone = 0;
    cfgLpEn = 0; cfgPhyMode = 2'b01; cyc(1);
    srReq = 1; dpdReq = 1;
    cyc(2);
    check("R10 sr chosen", cmdOp, 0);
    cyc(8);
    check("R10 srAck", srAck, 1);
    srReq = 0; dpdReq = 0;
    cyc(10);
    check("R2 idle at end", idle, 1);
    check("R9 scoreboard empty", expQ.size(), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule